// File: doc/BRIEF.md
# External Clock Ratio Divider

This block divides a fixed 96 MHz source down to an external clock. A 16-bit control word carries a 6-bit ratio code in bits [7:2]. The code maps onto the divisor in two linear pieces. The lower piece steps by one and covers divisors 2 to 8. The upper piece steps by two and covers divisors 10 to 96. Odd divisors above 8 therefore have no code. Bit 0 of the control word selects the clock source, and a value of 0 means the 96 MHz source. Every path that updates the ratio forces this bit to 0. Bit 1 and bits [15:8] are general bits that the block stores and preserves.

The control word can change in three ways. A direct register write stores a whole word. A rate request takes a target frequency in kHz, finds the fastest legal divisor whose output does not exceed the target, and writes the matching code. An initialise pulse forces the 96 MHz source and keeps the ratio that is already programmed. The divisor decoded from the current word is always visible on a port.

A separate clock-request input gates the output. While the request is low the output stays low. When the request is high the divider runs, with the high phase first. A new ratio is adopted only when the current output period ends, so a ratio change never shortens a phase.

Top module: `ext_clk_div`

## Requirements
- R1: Ratio codes 0 to 6 select a divisor of code + 2 (code 3 gives 5).
- R2: Ratio codes 7 to 50 select a divisor of 8 + 2*(code - 6) (code 20 gives 36, code 50 gives 96).
- R3: A ratio code above 50 in a direct write is stored as 50.
- R4: A direct write stores bits [15:1] as written, with the ratio clamped as in R3, and stores bit 0 as 0.
- R5: A rate request of F kHz selects the smallest legal divisor d in 2..96 for which floor(96000/d) <= F. Odd divisors above 8 are skipped. The code for d is written into bits [7:2].
- R6: When no legal divisor satisfies R5, the rate request selects divisor 96 (code 50).
- R7: A rate request clears bit 0 and leaves bit 1 and bits [15:8] unchanged.
- R8: An initialise pulse clears bit 0 and leaves every other bit unchanged.
- R9: After reset the control word reads 16'h0005 (divisor 3, bit 0 set) and the output is low.
- R10: While the clock request is low, the output is low from the next cycle onward. When the request rises, the output is high in the next cycle.
- R11: For divisor d, the output is high for floor(d/2) cycles and low for d - floor(d/2) cycles in each period.
- R12: A ratio change made during a period takes effect only after that period completes.
- R13: When operations arrive in the same cycle, a direct write wins over a rate request, and a rate request wins over an initialise pulse.
- R14: In a cycle with no operation, the control word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 96 MHz source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Direct write strobe |
| reg_wdata | input | 16 | Direct write data |
| rate_set | input | 1 | Rate request strobe |
| rate_khz | input | RATE_W (17) | Requested frequency in kHz |
| init_req | input | 1 | Initialise pulse |
| clk_req | input | 1 | Clock request; output runs while high |
| reg_rdata | output | 16 | Current control word |
| cur_div | output | 7 | Divisor decoded from the current ratio code |
| clk_out | output | 1 | Divided clock |

## Verification
The rounding corners are tested on both sides of each threshold: 48000 against 47999, 13714 against 13713, and the gap at 11999 where divisor 9 must be skipped. A divider that did not skip odd codes would return 9. An off-by-one comparison would return the neighbouring divisor. Requests of 999 and 0 must saturate at 96 and must not wrap to a small code. Other tests cover codes 51 and 63, which must clamp rather than alias, and odd divisors, where a wrong split would produce an inverted duty cycle. A ratio change is made mid-phase, and a block that reloaded early would cut that phase short.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

    localparam int CTRL_W     = 16;
    localparam int RATIO_W    = 6;
    localparam int RATIO_LSB  = 2;
    localparam int DIV_W      = 7;
    localparam int LIN_LAST   = 6;
    localparam int MAX_CODE   = 50;
    localparam int SRC_KHZ    = 96000;

    // Two-piece mapping: step one up to divisor 8, step two beyond.
    function automatic logic [DIV_W-1:0] code_to_div(input logic [RATIO_W-1:0] code);
        logic [DIV_W-1:0] c7;
        c7 = DIV_W'(code);
        if (code <= RATIO_W'(LIN_LAST))
            return c7 + DIV_W'(2);
        else
            return DIV_W'(8) + ((c7 - DIV_W'(LIN_LAST)) << 1);
    endfunction

    function automatic logic [RATIO_W-1:0] clamp_code(input logic [RATIO_W-1:0] code);
        if (code > RATIO_W'(MAX_CODE))
            return RATIO_W'(MAX_CODE);
        else
            return code;
    endfunction

    typedef struct packed {
        logic [CTRL_W-1:0] word;
    } ctrl_state_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             out;
    } div_state_t;

endpackage

// File: rtl/ecd_ctrl_reg.sv
module ecd_ctrl_reg
    import ecd_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_WORD = 16'h0005
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    input  logic                set_en,
    input  logic [RATIO_W-1:0]  set_code,
    input  logic                init_en,
    output logic [CTRL_W-1:0]   word_o
);

    localparam int RATIO_MSB = RATIO_LSB + RATIO_W - 1;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wr_data;
            st_d.word[RATIO_MSB:RATIO_LSB] = clamp_code(wr_data[RATIO_MSB:RATIO_LSB]);
            st_d.word[0] = 1'b0;
        end else if (set_en) begin
            st_d.word[RATIO_MSB:RATIO_LSB] = clamp_code(set_code);
            st_d.word[0] = 1'b0;
        end else if (init_en) begin
            st_d.word[0] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.word <= RESET_WORD;
        else
            st_q <= st_d;
    end

    assign word_o = st_q.word;

endmodule

// File: rtl/ecd_rate_round.sv
module ecd_rate_round
    import ecd_pkg::*;
#(
    parameter int RATE_W  = 17,
    parameter int SRC_RATE = SRC_KHZ
) (
    input  logic [RATE_W-1:0]   rate_khz,
    output logic [RATIO_W-1:0]  code_o
);

    localparam int NCODES = MAX_CODE + 1;
    localparam int PROD_W = RATE_W + 1 + DIV_W;

    logic [NCODES-1:0] fits;
    logic [PROD_W-1:0] req_p1;

    assign req_p1 = PROD_W'(rate_khz) + PROD_W'(1);

    // floor(SRC/d) <= F  is equivalent to  SRC < (F+1)*d
    genvar k;
    generate
        for (k = 0; k < NCODES; k++) begin : g_cand
            logic [DIV_W-1:0]  dv;
            logic [PROD_W-1:0] prod;
            assign dv      = code_to_div(RATIO_W'(k));
            assign prod    = req_p1 * PROD_W'(dv);
            assign fits[k] = prod > PROD_W'(SRC_RATE);
        end
    endgenerate

    // Divisor grows with code, so the lowest fitting code is the fastest legal rate.
    always_comb begin
        code_o = RATIO_W'(MAX_CODE);
        for (int i = NCODES - 1; i >= 0; i--) begin
            if (fits[i]) code_o = RATIO_W'(i);
        end
    end

endmodule

// File: rtl/ecd_div_core.sv
module ecd_div_core
    import ecd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [DIV_W-1:0]   div_sel,
    output logic               out_o
);

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            // Park at the last count so the first enabled cycle opens a fresh period.
            st_d.div = div_sel;
            st_d.cnt = div_sel - DIV_W'(1);
            st_d.out = 1'b0;
        end else begin
            if (st_q.cnt == st_q.div - DIV_W'(1)) begin
                st_d.cnt = '0;
                st_d.div = div_sel;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
            st_d.out = st_d.cnt < (st_d.div >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= DIV_W'(1);
            st_q.div <= DIV_W'(2);
            st_q.out <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

endmodule

// File: rtl/ext_clk_div.sv
module ext_clk_div
    import ecd_pkg::*;
#(
    parameter int                RATE_W     = 17,
    parameter int                SRC_RATE   = SRC_KHZ,
    parameter logic [CTRL_W-1:0] RESET_WORD = 16'h0005
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [CTRL_W-1:0]   reg_wdata,
    input  logic                rate_set,
    input  logic [RATE_W-1:0]   rate_khz,
    input  logic                init_req,
    input  logic                clk_req,
    output logic [CTRL_W-1:0]   reg_rdata,
    output logic [DIV_W-1:0]    cur_div,
    output logic                clk_out
);

    localparam int RATIO_MSB = RATIO_LSB + RATIO_W - 1;

    logic [RATIO_W-1:0] rounded_code;
    logic [CTRL_W-1:0]  word;

    ecd_rate_round #(
        .RATE_W   (RATE_W),
        .SRC_RATE (SRC_RATE)
    ) u_round (
        .rate_khz (rate_khz),
        .code_o   (rounded_code)
    );

    ecd_ctrl_reg #(
        .RESET_WORD (RESET_WORD)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .set_en   (rate_set),
        .set_code (rounded_code),
        .init_en  (init_req),
        .word_o   (word)
    );

    assign cur_div   = code_to_div(word[RATIO_MSB:RATIO_LSB]);
    assign reg_rdata = word;

    ecd_div_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (clk_req),
        .div_sel (cur_div),
        .out_o   (clk_out)
    );

endmodule

// File: rtl/ext_clk_div_chk.sv
module ext_clk_div_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        rate_set,
    input logic        init_req,
    input logic        clk_req,
    input logic [15:0] reg_rdata,
    input logic [6:0]  cur_div,
    input logic        clk_out
);

    assert_code_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:2] <= 6'd50);

    // R1 R2: decoded divisor always lands in the legal set
    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_div >= 7'd2 && cur_div <= 7'd96 && (cur_div <= 7'd8 || !cur_div[0]));

    assert_write_clears_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_rdata[0]);

    assert_rate_keeps_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_set && !reg_wr) |=> (reg_rdata[15:8] == $past(reg_rdata[15:8]))
                                 && (reg_rdata[1] == $past(reg_rdata[1]))
                                 && !reg_rdata[0]);

    assert_init_keeps_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !reg_wr && !rate_set) |=> (reg_rdata[15:1] == $past(reg_rdata[15:1]))
                                              && !reg_rdata[0]);

    assert_gated_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_req |=> !clk_out);

    assert_start_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_req) |=> clk_out);

    assert_hold_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !rate_set && !init_req) |=> $stable(reg_rdata));

endmodule

bind ext_clk_div ext_clk_div_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .rate_set  (rate_set),
    .init_req  (init_req),
    .clk_req   (clk_req),
    .reg_rdata (reg_rdata),
    .cur_div   (cur_div),
    .clk_out   (clk_out)
);

// File: tb/tb_ext_clk_div.sv
module tb_ext_clk_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        rate_set = 1'b0;
    logic [16:0] rate_khz = '0;
    logic        init_req = 1'b0;
    logic        clk_req = 1'b0;
    logic [15:0] reg_rdata;
    logic [6:0]  cur_div;
    logic        clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ext_clk_div dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .rate_set  (rate_set),
        .rate_khz  (rate_khz),
        .init_req  (init_req),
        .clk_req   (clk_req),
        .reg_rdata (reg_rdata),
        .cur_div   (cur_div),
        .clk_out   (clk_out)
    );

    // {request kHz, expected code, expected divisor}
    localparam int NV = 13;
    localparam logic [29:0] VEC [NV] = '{
        {17'd96000, 6'd0,  7'd2},
        {17'd48000, 6'd0,  7'd2},
        {17'd47999, 6'd1,  7'd3},
        {17'd24000, 6'd2,  7'd4},
        {17'd13714, 6'd5,  7'd7},
        {17'd13713, 6'd6,  7'd8},
        {17'd12000, 6'd6,  7'd8},
        {17'd11999, 6'd7,  7'd10},
        {17'd9600,  6'd7,  7'd10},
        {17'd9599,  6'd8,  7'd12},
        {17'd1000,  6'd50, 7'd96},
        {17'd999,   6'd50, 7'd96},
        {17'd0,     6'd50, 7'd96}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rate(input logic [16:0] f);
        @(negedge clk);
        rate_set = 1'b1; rate_khz = f;
        @(negedge clk);
        rate_set = 1'b0;
    endtask

    // Enable, then measure the first high and low phase lengths.
    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        @(negedge clk);
        clk_req = 1'b1;
        @(negedge clk);
        while (clk_out && hi < 200) begin hi++; @(negedge clk); end
        while (!clk_out && lo < 200) begin lo++; @(negedge clk); end
        clk_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int hi, lo;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset word", reg_rdata, 16'h0005);
        check("R9 reset div", cur_div, 3);
        check("R9 reset out", clk_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 initialise clears only bit 0
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
        check("R8 init word", reg_rdata, 16'h0004);

        // R5 R6 rounding table
        do_write(16'hA502);
        for (int i = 0; i < NV; i++) begin
            do_rate(VEC[i][29:13]);
            check("R5 rounded code", reg_rdata[7:2], VEC[i][12:7]);
            check("R6 rounded div", cur_div, VEC[i][6:0]);
            check("R7 kept bits", {reg_rdata[15:8], reg_rdata[1:0]}, {8'hA5, 2'b10});
        end

        // R1 R2 mapping
        do_write(16'h000C);
        check("R1 code3 div", cur_div, 5);
        do_write(16'h0050);
        check("R2 code20 div", cur_div, 36);
        // R3 clamp, R4 bit 0 cleared
        do_write(16'h00FD);
        check("R3 clamp 63", reg_rdata, 16'h00C8);
        check("R3 clamp div", cur_div, 96);
        do_write(16'h3ACF);
        check("R4 write word", reg_rdata, 16'h3ACA);

        // R13 priority
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 16'h0010; rate_set = 1'b1; rate_khz = 17'd96000; init_req = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R13 write wins", reg_rdata, 16'h0010);
        do_write(16'h4401);
        @(negedge clk);
        check("R13 rate over init", reg_rdata, 16'h4400);
        rate_set = 1'b0; init_req = 1'b0;

        // R14 hold
        repeat (4) @(negedge clk);
        check("R14 hold", reg_rdata, 16'h4400);

        // R10 gating
        do_write(16'h0000);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R10 gated low", clk_out, 0);
        end

        // R11 duty per divisor
        do_write(16'h0000); measure(hi, lo);
        check("R11 div2 hi", hi, 1); check("R11 div2 lo", lo, 1);
        do_write(16'h0004); measure(hi, lo);
        check("R11 div3 hi", hi, 1); check("R11 div3 lo", lo, 2);
        do_write(16'h0014); measure(hi, lo);
        check("R11 div7 hi", hi, 3); check("R11 div7 lo", lo, 4);
        do_write(16'h001C); measure(hi, lo);
        check("R11 div10 hi", hi, 5); check("R11 div10 lo", lo, 5);

        // R12 mid-period change: divisor 8 -> 2
        do_write(16'h0018);
        @(negedge clk);
        clk_req = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 16'h0000;
        hi = 1; lo = 0;
        @(negedge clk);
        reg_wr = 1'b0;
        while (clk_out && hi < 200) begin hi++; @(negedge clk); end
        while (!clk_out && lo < 200) begin lo++; @(negedge clk); end
        check("R12 old hi kept", hi, 4);
        check("R12 old lo kept", lo, 4);
        hi = 0; lo = 0;
        while (clk_out && hi < 200) begin hi++; @(negedge clk); end
        while (!clk_out && lo < 200) begin lo++; @(negedge clk); end
        check("R12 new hi", hi, 1);
        check("R12 new lo", lo, 1);
        clk_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 low after drop", clk_out, 0);

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule